// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is a synthesizable stand-in for a small three-wire serial EEPROM. A master drives a select line, a serial clock and a serial data input; the block answers on a single serial data output. Every instruction begins with a 1 start bit, followed by a two-bit opcode and an address field. A read shifts words out of an internal array, and the read carries on into the following addresses for as long as select stays high. A write takes one word of serial data. A group of special commands is coded in the top two address bits: they set or clear a write-enable latch, or erase the whole array.

The array holds `CAP_BYTES` bytes, organised either as bytes or as 16-bit words (`WORD16`). After a write or an erase-all, the block enters a programming period of `PROG_CYCLES` system clocks. This stands in for the roughly 6 ms program time of a real part, scaled down for simulation. During that period the output reports busy.

All three serial inputs are synchronised into the system clock domain, and the block acts on rising edges of the serial clock. The serial clock must therefore run well below the system clock; each half period should last at least `SYNC_STAGES + 2` system clocks. The serial link has no back-pressure. The master paces every bit, and the only flow control is the busy/ready level on the data output after programming. All pins are plain levels.

Top module: `mw_eeprom_target`

## Requirements
- R1: After reset the write-enable latch is clear, the output is 0 and no programming period is running. Array contents are not affected by reset.
- R2: While select is high, 0 bits are skipped until a 1 start bit arrives. The next two bits are the opcode, where 10 is read, 01 is write, 00 is special and 11 is ignored. The address then follows, MSB first.
- R3: The address width is log2(`CAP_BYTES`) for byte organisation and one less for 16-bit organisation. The data word is 8 or 16 bits wide to match.
- R4: On a read, the output is 0 (a dummy bit) once the last address bit has been clocked in. After each following serial-clock rising edge the output presents the next data bit, MSB first.
- R5: If serial clocking continues after the last bit of a word, the read moves on to the next address with no further dummy bit. After the highest address it wraps to address 0.
- R6: A write takes one data word, MSB first, after the address. The word is stored once its last bit has arrived, provided writes are enabled.
- R7: For the special opcode, the top two address bits select the command: 11 sets the write-enable latch, 00 clears it, and 10 sets every cell to all ones when writes are enabled. The value 01 and the lower address bits have no effect.
- R8: While the write-enable latch is clear, a write or erase-all leaves the array unchanged and starts no programming period.
- R9: A write or erase-all starts a programming period of `PROG_CYCLES` system clocks. While select is high and no new instruction has begun, the output is 0 during that period and 1 after it ends.
- R10: A start bit that arrives during a programming period is ignored, so no read data is driven.
- R11: If select goes low before an instruction completes, the instruction is abandoned and the array is unchanged.
- R12: The write-enable latch keeps its state across instructions until a disable command or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select from the master, active high |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data / ready-busy status to the master |

## Verification
The hardest situation to reach is a new instruction arriving while a programming period is still running. It must be ignored, and that can only be seen as an output that stays at 0.

The bench creates this situation by issuing a write and then, without waiting, raising select and clocking a complete read of an address known to hold ones. Every returned bit must be 0. Once the period has ended, a repeat of the same read must return the real word.

An abandoned write is tested in a similar way: it is followed at once by a read. That read succeeds only if no programming period was started and the array is unchanged.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_RLOAD,
    ST_READ,
    ST_HOLD
  } mw_state_e;

  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_READ    = 2'b10;

  localparam logic [1:0] SUB_LOCK    = 2'b00;
  localparam logic [1:0] SUB_ERASE   = 2'b10;
  localparam logic [1:0] SUB_UNLOCK  = 2'b11;
endpackage

// File: rtl/mw_front.sv
module mw_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sel_s,
  output logic sdi_s,
  output logic sclk_rise
);
  logic [STAGES-1:0][2:0] pipe;
  logic                   sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= {sel_i, sclk_i, sdi_i};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '0;
      else        pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= pipe[STAGES-1][1];
  end

  assign sel_s     = pipe[STAGES-1][2];
  assign sdi_s     = pipe[STAGES-1][0];
  assign sclk_rise = pipe[STAGES-1][1] & ~sclk_prev;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (start)           remain <= CW'(PROG_CYCLES);
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  // R9
  prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              erase_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic              sweeping
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [ADDR_W-1:0] sweep_ptr;
  logic              sweep_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_on  <= 1'b0;
      sweep_ptr <= '0;
    end else if (erase_stb) begin
      sweep_on  <= 1'b1;
      sweep_ptr <= '0;
    end else if (sweep_on) begin
      sweep_ptr <= sweep_ptr + 1'b1;
      if (&sweep_ptr) sweep_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (sweep_on)    cells[sweep_ptr] <= '1;
    else if (wr_stb) cells[wr_addr]   <= wr_word;
  end

  assign rd_word  = cells[rd_addr];
  assign sweeping = sweep_on;

  // R7
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_on && !erase_stb && !(&sweep_ptr)) |=> (sweep_on && sweep_ptr == $past(sweep_ptr) + 1'b1));
endmodule

// File: rtl/mw_decoder.sv
module mw_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_word,
  output logic              erase_stb,
  output logic              sdo
);
  localparam int MAXB = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CW   = $clog2(MAXB + 1);

  mw_state_e         state;
  logic [CW-1:0]     cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dsr;
  logic [DATA_W:0]   osr;
  logic              wen_q;
  logic              stat_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] dsr_nxt;

  assign addr_nxt = {addr[ADDR_W-2:0], sdi_s};
  assign dsr_nxt  = {dsr[DATA_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      opc       <= '0;
      addr      <= '0;
      dsr       <= '0;
      osr       <= '0;
      wen_q     <= 1'b0;
      stat_q    <= 1'b0;
      wr_stb    <= 1'b0;
      erase_stb <= 1'b0;
    end else begin
      wr_stb    <= 1'b0;
      erase_stb <= 1'b0;
      if (!sel_s) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (sclk_rise && sdi_s && !busy) begin
              state  <= ST_OPC;
              cnt    <= '0;
              stat_q <= 1'b0;
            end
          end
          ST_OPC: begin
            if (sclk_rise) begin
              opc <= {opc[0], sdi_s};
              if (cnt == CW'(1)) begin
                state <= ST_ADDR;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_ADDR: begin
            if (sclk_rise) begin
              addr <= addr_nxt;
              if (cnt == CW'(ADDR_W - 1)) begin
                cnt <= '0;
                unique case (opc)
                  OPC_READ:  state <= ST_RLOAD;
                  OPC_WRITE: state <= ST_DATA;
                  OPC_SPECIAL: begin
                    state <= ST_HOLD;
                    unique case (addr_nxt[ADDR_W-1 -: 2])
                      SUB_UNLOCK: wen_q <= 1'b1;
                      SUB_LOCK:   wen_q <= 1'b0;
                      SUB_ERASE: begin
                        if (wen_q) begin
                          erase_stb <= 1'b1;
                          stat_q    <= 1'b1;
                        end
                      end
                      default: ;
                    endcase
                  end
                  default: state <= ST_HOLD;
                endcase
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (sclk_rise) begin
              dsr <= dsr_nxt;
              if (cnt == CW'(DATA_W - 1)) begin
                state <= ST_HOLD;
                cnt   <= '0;
                if (wen_q) begin
                  wr_stb <= 1'b1;
                  stat_q <= 1'b1;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_RLOAD: begin
            osr   <= {1'b0, rd_word};
            addr  <= addr + 1'b1;
            cnt   <= '0;
            state <= ST_READ;
          end
          ST_READ: begin
            if (sclk_rise) begin
              if (cnt == CW'(DATA_W)) begin
                osr  <= {rd_word, 1'b0};
                addr <= addr + 1'b1;
                cnt  <= CW'(1);
              end else begin
                osr <= {osr[DATA_W-1:0], 1'b0};
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cur_addr = addr;
  assign wr_word  = dsr;
  assign sdo      = (state == ST_READ) ? osr[DATA_W]
                  : (stat_q && sel_s)  ? ~busy
                  : 1'b0;

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> (state == ST_IDLE));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && busy) |=> (state == ST_IDLE));

  // R8
  wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || erase_stb) |-> $past(wen_q));

  // R4
  dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RLOAD) |=> !sdo);
endmodule

// File: rtl/mw_eeprom_target.sv
module mw_eeprom_target #(
  parameter int CAP_BYTES   = 128,
  parameter bit WORD16      = 1'b1,
  parameter int PROG_CYCLES = 6000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);
  localparam int ADDR_W = $clog2(CAP_BYTES) - (WORD16 ? 1 : 0);
  localparam int DATA_W = WORD16 ? 16 : 8;

  logic              sel_s, sdi_s, sclk_rise;
  logic              wr_stb, erase_stb, sweeping, timer_busy, busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] wr_word, rd_word;

  mw_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sel_s(sel_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise)
  );

  mw_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sdi_s(sdi_s),
    .sclk_rise(sclk_rise), .busy(busy), .rd_word(rd_word),
    .cur_addr(cur_addr), .wr_stb(wr_stb), .wr_word(wr_word),
    .erase_stb(erase_stb), .sdo(sdo_o)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(cur_addr),
    .wr_word(wr_word), .erase_stb(erase_stb), .rd_addr(cur_addr),
    .rd_word(rd_word), .sweeping(sweeping)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(wr_stb | erase_stb), .busy(timer_busy)
  );

  assign busy = timer_busy | sweeping;

  // R9
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_s && $past(busy) && $past(sel_s) && !$past(sclk_rise)
     && $past(u_dec.state) == mw_pkg::ST_HOLD) |-> !sdo_o);
endmodule

// File: tb/test_mw_eeprom_target.sv
module test_mw_eeprom_target;
  localparam int CAP  = 128;
  localparam int PROG = 600;
  localparam int AW   = 6;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  mw_eeprom_target #(.CAP_BYTES(CAP), .WORD16(1'b1), .PROG_CYCLES(PROG)) i_mw_eeprom_target (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    sdi = b; sclk = 1'b0; tick(5);
    sclk = 1'b1; tick(5);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic get_bit(output logic b);
    sclk = 1'b0; tick(5);
    b = sdo;
    sclk = 1'b1; tick(5);
  endtask

  task automatic sel_on;  sel = 1'b1; sclk = 1'b0; tick(4); endtask
  task automatic sel_off; sclk = 1'b0; sel = 1'b0; sdi = 1'b0; tick(6); endtask

  task automatic get_word(output logic [DW-1:0] w);
    logic b;
    for (int i = DW - 1; i >= 0; i--) begin get_bit(b); w[i] = b; end
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic b; logic [DW-1:0] w;
    sel_on; send({1'b1, 2'b10, a}, 3 + AW);
    get_bit(b); chk({req, " dummy"}, b, 0);
    get_word(w); chk(req, w, exp);
    sel_off;
  endtask

  task automatic write_w(input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_on; send({1'b1, 2'b01, a}, 3 + AW); send(d, DW); sel_off;
  endtask

  task automatic special(input logic [1:0] sub);
    sel_on; send({1'b1, 2'b00, sub, {(AW-2){1'b1}}}, 3 + AW); sel_off;
  endtask

  task automatic t_reset;
    chk("R1 sdo after reset", sdo, 0);
    sel_on; chk("R1 no status after reset", sdo, 0); sel_off;
  endtask

  task automatic t_write_read;
    special(2'b11);
    write_w(6'd0, 16'hA5C3);
    sel_on; tick(5); chk("R9 busy low", sdo, 0);
    tick(PROG); chk("R9 ready high", sdo, 1); sel_off;
    write_w(6'd63, 16'h0F0F); tick(PROG + 20);
    write_w(6'd1, 16'h8001);  tick(PROG + 20);
    write_w(6'd2, 16'h7E00);  tick(PROG + 20);
    read_chk("R6 R3 addr0", 6'd0, 16'hA5C3);
    read_chk("R6 addr63", 6'd63, 16'h0F0F);
    read_chk("R4 addr2", 6'd2, 16'h7E00);
  endtask

  task automatic t_sequential;
    logic b; logic [DW-1:0] w;
    sel_on; send({1'b1, 2'b10, 6'd63}, 3 + AW);
    get_bit(b); chk("R4 dummy seq", b, 0);
    get_word(w); chk("R5 first", w, 16'h0F0F);
    get_word(w); chk("R5 wrap to 0", w, 16'hA5C3);
    get_word(w); chk("R5 next", w, 16'h8001);
    sel_off;
  endtask

  task automatic t_leading_zeros;
    logic b; logic [DW-1:0] w;
    sel_on; send(3'b000, 3); send({1'b1, 2'b10, 6'd1}, 3 + AW);
    get_bit(b); get_word(w); chk("R2 leading zeros skipped", w, 16'h8001);
    sel_off;
  endtask

  task automatic t_disabled;
    special(2'b00);
    write_w(6'd1, 16'h1111);
    read_chk("R8 write ignored when locked", 6'd1, 16'h8001);
    special(2'b10);
    read_chk("R8 erase ignored when locked", 6'd2, 16'h7E00);
  endtask

  task automatic t_abort;
    special(2'b11);
    sel_on; send({1'b1, 2'b01, 6'd2}, 3 + AW); send(8'hFF, 8); sel_off;
    read_chk("R11 aborted write", 6'd2, 16'h7E00);
    special(2'b01);
    read_chk("R7 sub 01 no effect", 6'd0, 16'hA5C3);
  endtask

  task automatic t_busy_ignore;
    logic b; logic [DW-1:0] w;
    write_w(6'd3, 16'h3C3C);
    sel_on; send({1'b1, 2'b10, 6'd0}, 3 + AW);
    get_bit(b); get_word(w);
    chk("R10 start ignored while busy", {b, w}, 0);
    sel_off; tick(PROG + 20);
    read_chk("R10 read after busy", 6'd0, 16'hA5C3);
    read_chk("R12 latch kept across writes", 6'd3, 16'h3C3C);
  endtask

  task automatic t_erase;
    special(2'b10);
    sel_on; tick(5); chk("R9 erase busy", sdo, 0);
    tick(PROG + 20); chk("R9 erase ready", sdo, 1); sel_off;
    read_chk("R7 erase addr0", 6'd0, 16'hFFFF);
    read_chk("R7 erase addr3", 6'd3, 16'hFFFF);
    read_chk("R7 erase addr63", 6'd63, 16'hFFFF);
  endtask

  task automatic t_reset_latch;
    special(2'b11);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    write_w(6'd5, 16'h1234);
    read_chk("R1 R12 latch cleared by reset", 6'd5, 16'hFFFF);
  endtask

  initial begin
    tick(4); rst_n = 1'b1; tick(4);
    t_reset;
    t_write_read;
    t_sequential;
    t_leading_zeros;
    t_disabled;
    t_abort;
    t_busy_ignore;
    t_erase;
    t_reset_latch;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule